// File: doc/BRIEF.md
# Luma/Chroma Separating 64-bit Packer

This block sits behind a video capture front end that delivers 8-bit 4:2:2 samples on two byte lanes of a 20-bit bus. Bits 9:2 carry luma (Y). Bits 19:12 carry chroma, alternating Cb and Cr. Each qualified sample is split into three component streams. Each stream is gathered into 64-bit words holding eight samples of a single component. The first sample of a word goes into the least significant byte.

Every finished word is written into the FIFO for its component. The luma FIFO holds twice as many words as each chroma FIFO, because a chroma stream fills at half the luma rate. A downstream mover drains each FIFO through its own read-only 64-bit port, which shows the oldest word and advances on a read strobe.

A line-start input realigns the word assembly and the Cb/Cr phase. If a word completes while its FIFO is full, the word is dropped and a sticky per-component overrun flag is raised. Software later clears that flag with a write strobe.

Top module: `ycpack_top`

## Requirements
- R1: After reset, all three FIFOs report empty and not full, and all three overrun flags (bit 0 luma, bit 1 Cb, bit 2 Cr) read 0.
- R2: Each cycle with `sampleValid` high takes one luma sample from `pixBus[9:2]`. Eight such samples form one luma word, with the first sample in bits 7:0 and the eighth in bits 63:56. The word is readable (empty low) right after the clock edge that takes the eighth sample.
- R3: On valid cycles, `pixBus[19:12]` alternates Cb, Cr, Cb, Cr, … starting with Cb. Eight Cb samples make one Cb word and eight Cr samples make one Cr word, with the same byte order as R2. So each chroma FIFO gains one word per sixteen valid samples.
- R4: A cycle with `sampleValid` low changes no FIFO and no packing state, whatever `pixBus` holds.
- R5: `lineStart` high discards all partially built words and resets the chroma phase to Cb. A valid sample in the same cycle is taken as byte 0 of each word and as a Cb sample.
- R6: The luma FIFO holds `LUMA_DEPTH` words and each chroma FIFO holds `LUMA_DEPTH/2` words. A full flag is high exactly when its FIFO holds that many words, and words leave in arrival order.
- R7: A read strobe on a non-empty FIFO removes the word shown on its data port. A read strobe on an empty FIFO has no effect.
- R8: A word that completes while its FIFO is full is dropped, the FIFO contents stay unchanged, and that component's overrun flag is set. The flag stays set until cleared.
- R9: An `ovrClear` bit clears the matching overrun flag at the next edge. If a drop happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies the sample on `pixBus` |
| lineStart | input | 1 | Realigns packing and the chroma phase |
| pixBus | input | 20 | Luma in bits 9:2, chroma in bits 19:12 |
| lumaRdEn | input | 1 | Pop strobe for the luma FIFO |
| lumaRdData | output | 64 | Oldest luma word |
| lumaEmpty | output | 1 | Luma FIFO empty |
| lumaFull | output | 1 | Luma FIFO full |
| cbRdEn | input | 1 | Pop strobe for the Cb FIFO |
| cbRdData | output | 64 | Oldest Cb word |
| cbEmpty | output | 1 | Cb FIFO empty |
| cbFull | output | 1 | Cb FIFO full |
| crRdEn | input | 1 | Pop strobe for the Cr FIFO |
| crRdData | output | 64 | Oldest Cr word |
| crEmpty | output | 1 | Cr FIFO empty |
| crFull | output | 1 | Cr FIFO full |
| ovrClear | input | 3 | Write-one-to-clear for the overrun flags |
| ovrFlags | output | 3 | Sticky overrun flags (Y, Cb, Cr) |

## Verification
The bench sweeps the position of `lineStart` over all sixteen offsets within a chroma word period.

- A design that failed to reset the phase would swap the Cb and Cr words.
- A design that kept stale partial bytes would put them into the first word of the new line.

Valid-low gaps carry junk on the bus, so a design that sampled on them would show shifted bytes. Overrun is driven past full on all three FIFOs, and the drained contents are then compared. A design that overwrote a word or advanced a pointer on a drop would return the wrong words. The bench also places a clear and a drop in the same cycle, which exposes a design that lets the clear win.

// File: rtl/ycpack_pkg.sv
package ycpack_pkg;
  localparam int SAMPLE_W   = 8;
  localparam int WORD_W     = 64;
  localparam int SLOTS      = WORD_W / SAMPLE_W;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int NUM_COMP   = 3;
  localparam int COMP_Y     = 0;
  localparam int COMP_CB    = 1;
  localparam int COMP_CR    = 2;
  localparam int BUS_W      = 20;
  localparam int LUMA_LSB   = 2;
  localparam int CHROMA_LSB = 12;

  typedef struct packed {
    logic              load;
    logic [SLOT_W-1:0] slot;
    logic              push;
  } laneStrobe_t;

  typedef struct packed {
    laneStrobe_t [NUM_COMP-1:0] lane;
  } packStrobes_t;
endpackage

// File: rtl/ycpack_fifo.sv
module ycpack_fifo #(
  parameter int DEPTH = 160,
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doWr, doRd;

  assign empty  = (count == '0);
  assign full   = (count == MAX_CNT);
  assign doWr   = wrEn & ~full;
  assign doRd   = rdEn & ~empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ycpack_ctrl.sv
module ycpack_ctrl
  import ycpack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic                lineStart,
  input  logic [NUM_COMP-1:0] fifoFull,
  input  logic [NUM_COMP-1:0] ovrClear,
  output packStrobes_t        strobes,
  output logic [NUM_COMP-1:0] ovrFlags
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slotCnt  [NUM_COMP];
  logic [SLOT_W-1:0] slotBase [NUM_COMP];
  logic              chromaPhase, phaseBase;
  logic [NUM_COMP-1:0] take, complete, drop;

  always_comb begin
    phaseBase      = lineStart ? 1'b0 : chromaPhase;
    take[COMP_Y]   = sampleValid;
    take[COMP_CB]  = sampleValid & ~phaseBase;
    take[COMP_CR]  = sampleValid &  phaseBase;
    for (int c = 0; c < NUM_COMP; c++) begin
      slotBase[c]             = lineStart ? '0 : slotCnt[c];
      complete[c]             = take[c] && (slotBase[c] == LAST_SLOT);
      drop[c]                 = complete[c] & fifoFull[c];
      strobes.lane[c].load    = take[c];
      strobes.lane[c].slot    = slotBase[c];
      strobes.lane[c].push    = complete[c] & ~fifoFull[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chromaPhase <= 1'b0;
      ovrFlags    <= '0;
      for (int c = 0; c < NUM_COMP; c++) slotCnt[c] <= '0;
    end else begin
      chromaPhase <= sampleValid ? ~phaseBase : phaseBase;
      for (int c = 0; c < NUM_COMP; c++) begin
        slotCnt[c]  <= take[c] ? slotBase[c] + 1'b1 : slotBase[c];
        ovrFlags[c] <= drop[c] | (ovrFlags[c] & ~ovrClear[c]);
      end
    end
  end
endmodule

// File: rtl/ycpack_dpath.sv
module ycpack_dpath
  import ycpack_pkg::*;
#(
  parameter int LUMA_DEPTH   = 320,
  parameter int CHROMA_DEPTH = 160
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [BUS_W-1:0]                 pixBus,
  input  packStrobes_t                     strobes,
  input  logic [NUM_COMP-1:0]              rdEn,
  output logic [NUM_COMP-1:0][WORD_W-1:0]  rdData,
  output logic [NUM_COMP-1:0]              fifoEmpty,
  output logic [NUM_COMP-1:0]              fifoFull
);
  localparam int PART_W = WORD_W - SAMPLE_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SAMPLE_W-1:0] laneSample [NUM_COMP];
  logic [PART_W-1:0]   partial    [NUM_COMP];
  logic                unusedLaneBits;

  assign unusedLaneBits = ^{pixBus[LUMA_LSB-1:0], pixBus[CHROMA_LSB-1:LUMA_LSB+SAMPLE_W]};

  always_comb begin
    laneSample[COMP_Y]  = pixBus[LUMA_LSB +: SAMPLE_W];
    laneSample[COMP_CB] = pixBus[CHROMA_LSB +: SAMPLE_W];
    laneSample[COMP_CR] = pixBus[CHROMA_LSB +: SAMPLE_W];
  end

  // Bytes of a word below the last slot wait here; the last byte goes
  // straight into the FIFO together with them.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_COMP; c++) partial[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_COMP; c++) begin
        if (strobes.lane[c].load && strobes.lane[c].slot != LAST_SLOT)
          partial[c][strobes.lane[c].slot*SAMPLE_W +: SAMPLE_W] <= laneSample[c];
      end
    end
  end

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    localparam int DEPTH = (c == COMP_Y) ? LUMA_DEPTH : CHROMA_DEPTH;
    logic [WORD_W-1:0] pushWord;
    assign pushWord = {laneSample[c], partial[c]};

    ycpack_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (strobes.lane[c].push),
      .wrData (pushWord),
      .rdEn   (rdEn[c]),
      .rdData (rdData[c]),
      .empty  (fifoEmpty[c]),
      .full   (fifoFull[c])
    );
  end
endmodule

// File: rtl/ycpack_top.sv
module ycpack_top
  import ycpack_pkg::*;
#(
  parameter int LUMA_DEPTH = 320
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              lineStart,
  input  logic [19:0]       pixBus,
  input  logic              lumaRdEn,
  output logic [63:0]       lumaRdData,
  output logic              lumaEmpty,
  output logic              lumaFull,
  input  logic              cbRdEn,
  output logic [63:0]       cbRdData,
  output logic              cbEmpty,
  output logic              cbFull,
  input  logic              crRdEn,
  output logic [63:0]       crRdData,
  output logic              crEmpty,
  output logic              crFull,
  input  logic [2:0]        ovrClear,
  output logic [2:0]        ovrFlags
);
  localparam int CHROMA_DEPTH = LUMA_DEPTH / 2;

  packStrobes_t                    strobes;
  logic [NUM_COMP-1:0]             fifoFull, fifoEmpty, rdEn;
  logic [NUM_COMP-1:0][WORD_W-1:0] rdData;

  assign rdEn = {crRdEn, cbRdEn, lumaRdEn};

  ycpack_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .lineStart   (lineStart),
    .fifoFull    (fifoFull),
    .ovrClear    (ovrClear),
    .strobes     (strobes),
    .ovrFlags    (ovrFlags)
  );

  ycpack_dpath #(.LUMA_DEPTH(LUMA_DEPTH), .CHROMA_DEPTH(CHROMA_DEPTH)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .pixBus    (pixBus),
    .strobes   (strobes),
    .rdEn      (rdEn),
    .rdData    (rdData),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull)
  );

  assign lumaRdData = rdData[COMP_Y];
  assign cbRdData   = rdData[COMP_CB];
  assign crRdData   = rdData[COMP_CR];
  assign lumaEmpty  = fifoEmpty[COMP_Y];
  assign cbEmpty    = fifoEmpty[COMP_CB];
  assign crEmpty    = fifoEmpty[COMP_CR];
  assign lumaFull   = fifoFull[COMP_Y];
  assign cbFull     = fifoFull[COMP_CB];
  assign crFull     = fifoFull[COMP_CR];
endmodule

// File: rtl/ycpack_chk.sv
module ycpack_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sampleValid,
  input logic       lumaRdEn,
  input logic       lumaEmpty,
  input logic       lumaFull,
  input logic       cbRdEn,
  input logic       cbEmpty,
  input logic       cbFull,
  input logic       crRdEn,
  input logic       crEmpty,
  input logic       crFull,
  input logic [2:0] ovrClear,
  input logic [2:0] ovrFlags
);
  logic [2:0] rdEnV, emptyV, fullV;
  assign rdEnV  = {crRdEn, cbRdEn, lumaRdEn};
  assign emptyV = {crEmpty, cbEmpty, lumaEmpty};
  assign fullV  = {crFull, cbFull, lumaFull};

  for (genvar c = 0; c < 3; c++) begin : g_c
    // R6
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(fullV[c] && emptyV[c]));
    // R4
    idle_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
      emptyV[c] && !sampleValid |=> emptyV[c]);
    // R6
    full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
      fullV[c] && !rdEnV[c] |=> fullV[c]);
    // R7
    pop_frees_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
      !emptyV[c] && rdEnV[c] |=> !fullV[c]);
    // R8
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovrFlags[c]) |-> $past(fullV[c]));
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      ovrFlags[c] && !ovrClear[c] |=> ovrFlags[c]);
  end
endmodule

bind ycpack_top ycpack_chk u_chk (.*);

// File: tb/ycpack_top_bench.sv
module ycpack_top_bench;
  localparam int LD = 8;
  localparam int CD = LD / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sampleValid, lineStart;
  logic [19:0] pixBus;
  logic lumaRdEn, cbRdEn, crRdEn;
  logic [63:0] lumaRdData, cbRdData, crRdData;
  logic lumaEmpty, lumaFull, cbEmpty, cbFull, crEmpty, crFull;
  logic [2:0] ovrClear, ovrFlags;

  ycpack_top #(.LUMA_DEPTH(LD)) u_ycpack_top (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .lineStart(lineStart),
    .pixBus(pixBus),
    .lumaRdEn(lumaRdEn), .lumaRdData(lumaRdData), .lumaEmpty(lumaEmpty), .lumaFull(lumaFull),
    .cbRdEn(cbRdEn), .cbRdData(cbRdData), .cbEmpty(cbEmpty), .cbFull(cbFull),
    .crRdEn(crRdEn), .crRdData(crRdData), .crEmpty(crEmpty), .crFull(crFull),
    .ovrClear(ovrClear), .ovrFlags(ovrFlags)
  );

  // reference state derived from the requirements
  logic [63:0] qY[$], qB[$], qR[$];
  logic [63:0] partY, partB, partR;
  int cY, cB, cR, sIdx, nChk, nFail;
  bit ph, done;
  logic [2:0] expOvr;

  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  task automatic modelSample(logic [7:0] yb, logic [7:0] cb8);
    partY[cY*8 +: 8] = yb; cY++;
    if (cY == 8) begin
      if (qY.size() < LD) qY.push_back(partY); else expOvr[0] = 1'b1;
      cY = 0;
    end
    if (!ph) begin
      partB[cB*8 +: 8] = cb8; cB++;
      if (cB == 8) begin
        if (qB.size() < CD) qB.push_back(partB); else expOvr[1] = 1'b1;
        cB = 0;
      end
    end else begin
      partR[cR*8 +: 8] = cb8; cR++;
      if (cR == 8) begin
        if (qR.size() < CD) qR.push_back(partR); else expOvr[2] = 1'b1;
        cR = 0;
      end
    end
    ph = ~ph;
  endtask

  task automatic sendSample(bit ls, logic [2:0] clr, bit valid);
    logic [7:0] yb, cb8;
    yb  = 8'(sIdx * 37 + 5);
    cb8 = 8'(sIdx * 91 + 17);
    sIdx++;
    @(negedge clk);
    pixBus      = {cb8, 2'b11, yb, 2'b10};
    sampleValid = valid;
    lineStart   = ls;
    ovrClear    = clr;
    @(posedge clk);
    #1;
    sampleValid = 1'b0;
    lineStart   = 1'b0;
    ovrClear    = 3'b000;
    pixBus      = ~pixBus;
    expOvr = expOvr & ~clr;
    if (ls) begin cY = 0; cB = 0; cR = 0; ph = 1'b0; end
    if (valid) modelSample(yb, cb8);
  endtask

  task automatic checkStatus(string tag);
    chk(lumaEmpty == (qY.size() == 0), {tag, " lumaEmpty"}, 64'(lumaEmpty), 64'(qY.size() == 0));
    chk(cbEmpty == (qB.size() == 0), {tag, " cbEmpty"}, 64'(cbEmpty), 64'(qB.size() == 0));
    chk(crEmpty == (qR.size() == 0), {tag, " crEmpty"}, 64'(crEmpty), 64'(qR.size() == 0));
    chk(lumaFull == (qY.size() == LD), {tag, " lumaFull"}, 64'(lumaFull), 64'(qY.size() == LD));
    chk(cbFull == (qB.size() == CD), {tag, " cbFull"}, 64'(cbFull), 64'(qB.size() == CD));
    chk(crFull == (qR.size() == CD), {tag, " crFull"}, 64'(crFull), 64'(qR.size() == CD));
    chk(ovrFlags == expOvr, {tag, " ovrFlags"}, 64'(ovrFlags), 64'(expOvr));
  endtask

  task automatic popCheck(int comp, string tag);
    logic [63:0] exp, act;
    bit emp;
    case (comp)
      0: begin exp = qY.pop_front(); act = lumaRdData; emp = lumaEmpty; lumaRdEn = 1'b1; end
      1: begin exp = qB.pop_front(); act = cbRdData;   emp = cbEmpty;   cbRdEn   = 1'b1; end
      default: begin exp = qR.pop_front(); act = crRdData; emp = crEmpty; crRdEn = 1'b1; end
    endcase
    chk(!emp, {tag, " not empty before read"}, 64'(emp), 64'(0));
    chk(act == exp, {tag, " word"}, act, exp);
    @(posedge clk);
    #1;
    lumaRdEn = 1'b0; cbRdEn = 1'b0; crRdEn = 1'b0;
  endtask

  task automatic drainAll(string tYc, string tC);
    while (qY.size() > 0) popCheck(0, tYc);
    while (qB.size() > 0) popCheck(1, tC);
    while (qR.size() > 0) popCheck(2, tC);
    checkStatus(tC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    nChk = 0; nFail = 0; sIdx = 0; done = 1'b0;
    cY = 0; cB = 0; cR = 0; ph = 1'b0; expOvr = 3'b000;
    partY = '0; partB = '0; partR = '0;
    rstN = 1'b0; sampleValid = 1'b0; lineStart = 1'b0; pixBus = '0;
    lumaRdEn = 1'b0; cbRdEn = 1'b0; crRdEn = 1'b0; ovrClear = 3'b000;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    checkStatus("R1 reset");

    // R2 R3 R4: sixteen samples with idle gaps carrying junk
    for (int i = 0; i < 16; i++) begin
      sendSample(1'b0, 3'b000, 1'b1);
      checkStatus("R2 fill");
      if (i % 3 == 1) begin
        sendSample(1'b0, 3'b000, 1'b0);
        checkStatus("R4 idle");
      end
    end
    drainAll("R2 luma", "R3 chroma");

    // R5: line start at every offset within a chroma word period
    for (int off = 0; off < 16; off++) begin
      for (int i = 0; i < off; i++) sendSample(1'b0, 3'b000, 1'b1);
      sendSample(1'b1, 3'b000, 1'b1);
      for (int i = 0; i < 15; i++) sendSample(1'b0, 3'b000, 1'b1);
      checkStatus("R5 realign");
      drainAll("R5 luma", "R5 chroma");
    end

    // R6 R8: fill past full on all three FIFOs
    sendSample(1'b1, 3'b000, 1'b1);
    for (int i = 0; i < 79; i++) begin
      sendSample(1'b0, 3'b000, 1'b1);
      checkStatus("R6 R8 overrun");
    end
    chk(ovrFlags == 3'b111, "R8 all flags", 64'(ovrFlags), 64'(3'b111));
    drainAll("R8 luma kept", "R8 chroma kept");

    // R7: reads on empty FIFOs have no effect
    lumaRdEn = 1'b1; cbRdEn = 1'b1; crRdEn = 1'b1;
    @(posedge clk);
    #1;
    lumaRdEn = 1'b0; cbRdEn = 1'b0; crRdEn = 1'b0;
    checkStatus("R7 empty read");
    sendSample(1'b1, 3'b000, 1'b1);
    for (int i = 0; i < 15; i++) sendSample(1'b0, 3'b000, 1'b1);
    checkStatus("R7 after empty read");
    drainAll("R7 luma", "R7 chroma");

    // R9: clear one flag, then the others
    sendSample(1'b0, 3'b001, 1'b0);
    checkStatus("R9 clear luma");
    sendSample(1'b0, 3'b110, 1'b0);
    checkStatus("R9 clear chroma");

    // R9: a drop in the same cycle as the clear keeps the flag
    sendSample(1'b1, 3'b000, 1'b1);
    for (int i = 0; i < 63; i++) sendSample(1'b0, 3'b000, 1'b1);
    for (int i = 0; i < 7; i++) sendSample(1'b0, 3'b000, 1'b1);
    checkStatus("R9 before clash");
    sendSample(1'b0, 3'b001, 1'b1);
    checkStatus("R9 set beats clear");
    chk(ovrFlags[0] == 1'b1, "R9 luma flag kept", 64'(ovrFlags[0]), 64'(1));
    drainAll("R9 luma", "R9 chroma");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule